// File: doc/BRIEF.md
# Masked Strided Vector Address Generator

This block turns one vector memory instruction into a stream of per-element requests. When a start pulse arrives, it captures a base byte address, a signed byte stride, an addressing mode (constant stride or indexed), an element size (4-byte longword or 8-byte quadword), an element count and a 64-bit per-element mask with its enable and polarity controls. It then emits one request for every element that survives both the length limit and the mask test. Each request carries the byte address, the element number and a width flag.

In indexed mode, used for gather and scatter, the block places the number of the element it is about to issue on an index read port. The register file answers in the same cycle with that element's 64-bit offset. The generator adds the offset to the base. For longword operations only the low 32 bits of the offset are used, sign-extended. Requests leave through a valid/ready handshake in ascending element order. A single-cycle done pulse marks the end of the instruction.

Top module: `vec_addr_gen`

## Requirements
- R1: While reset is high, and on the first cycle after it, `req_valid` and `done` are low. A reset during an instruction abandons it: no further requests and no done pulse follow until a new start.
- R2: Only elements whose number is below `vlen` are issued. A `vlen` of 64 or more (the port is 7 bits) issues elements 0 to 63. A `vlen` of 0 issues none.
- R3: When `mask_en` is 1, element i is issued only if `mask[i]` equals `match_true` (1 selects set bits, 0 selects clear bits). When `mask_en` is 0, the mask is ignored.
- R4: In stride mode (`gather`=0), element i has address `base_addr + i*stride` modulo 2^48, with `stride` taken as a two's-complement byte count.
- R5: In indexed mode (`gather`=1), element i has address `base_addr + offset(i)` modulo 2^48. The offset comes from `idx_rd_data` while `idx_rd_addr` equals i.
- R6: With `quad`=0, the offset is bits 31:0 of the index element, sign-extended, and bits 63:32 have no effect. With `quad`=1, the offset is bits 47:0. `req_quad` repeats `quad`: 1 means an 8-byte element and 0 means a 4-byte element.
- R7: Requests leave in strictly ascending element order, at most one per cycle, and one per cycle when `req_ready` stays high. While `req_valid` is high and `req_ready` is low, the request stays unchanged.
- R8: `done` is a one-cycle pulse in the cycle after the last request is accepted. If no element is enabled, it comes in the cycle after start instead. No request is valid while `done` is high.
- R9: A start pulse that arrives while an instruction is in progress is ignored. The parameters captured at the accepted start govern every request of that instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an instruction (accepted when idle) |
| base_addr | input | 48 | Base byte address |
| stride | input | 48 | Signed byte distance between consecutive elements |
| gather | input | 1 | 1 selects indexed addressing |
| quad | input | 1 | 1 selects quadword elements, 0 selects longword |
| vlen | input | 7 | Element count |
| mask | input | 64 | Per-element mask bits |
| mask_en | input | 1 | Applies the mask |
| match_true | input | 1 | Mask polarity that enables an element |
| idx_rd_addr | output | 6 | Element whose index offset is wanted |
| idx_rd_data | input | 64 | Index element returned in the same cycle |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Downstream accepts the request |
| req_addr | output | 48 | Element byte address |
| req_elem | output | 6 | Element number |
| req_quad | output | 1 | Element width flag |
| done | output | 1 | Instruction finished pulse |

## Verification
The main function is exercised with the following cases:
- Positive and negative strides, with one stride chosen so that the addresses wrap past the top of the 48-bit space. These separate correct signed, modular address arithmetic from unsigned or truncated arithmetic.
- Alternating and sparse masks under both polarities, plus the mask disabled while its bits are non-zero. These separate the polarity choice from the enable bit.
- Indexed runs in both element sizes, against index elements whose upper words hold non-zero values and whose low words are sometimes negative. These show whether sign extension and the choice of offset bits are correct.
- Lengths of 0, a fully masked length of 64, and an oversized length. These pin down done timing when nothing issues, and the saturation at 64.
- Irregular ready patterns, and a second start injected mid-run. These expose payload changes under backpressure and any restart of an instruction already in progress.

// File: rtl/vag_pkg.sv
package vag_pkg;
  typedef enum logic [0:0] {
    VAG_IDLE = 1'b0,
    VAG_RUN  = 1'b1
  } vag_state_e;

  localparam int unsigned VAG_LONG_BITS = 32;
endpackage

// File: rtl/vag_enable_gen.sv
module vag_enable_gen #(
  parameter int unsigned NUM_ELEM = 64,
  parameter int unsigned LEN_W    = $clog2(NUM_ELEM + 1)
) (
  input  logic [LEN_W-1:0]    vlen,
  input  logic [NUM_ELEM-1:0] mask,
  input  logic                mask_en,
  input  logic                match_true,
  output logic [NUM_ELEM-1:0] en_vec
);
  for (genvar g = 0; g < NUM_ELEM; g++) begin : g_lane
    localparam logic [LEN_W:0] LANE = (LEN_W+1)'(g);
    logic in_len;
    logic mask_ok;
    assign in_len   = ({1'b0, vlen} > LANE);
    assign mask_ok  = !mask_en || (mask[g] == match_true);
    assign en_vec[g] = in_len && mask_ok;
  end
endmodule

// File: rtl/vag_pick_lowest.sv
module vag_pick_lowest #(
  parameter int unsigned NUM_ELEM = 64,
  parameter int unsigned IDX_W    = $clog2(NUM_ELEM)
) (
  input  logic [NUM_ELEM-1:0] pend,
  output logic [IDX_W-1:0]    sel_idx,
  output logic [NUM_ELEM-1:0] sel_onehot,
  output logic                sel_any
);
  always_comb begin
    sel_idx = '0;
    for (int i = NUM_ELEM - 1; i >= 0; i--) begin
      if (pend[i]) sel_idx = IDX_W'(i);
    end
  end

  assign sel_onehot = pend & (~pend + NUM_ELEM'(1));
  assign sel_any    = |pend;
endmodule

// File: rtl/vag_addr_calc.sv
module vag_addr_calc #(
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned ELEM_W = 64,
  parameter int unsigned IDX_W  = 6
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] stride,
  input  logic              gather,
  input  logic              quad,
  input  logic [IDX_W-1:0]  elem,
  input  logic [ELEM_W-1:0] idx_data,
  output logic [ADDR_W-1:0] addr
);
  import vag_pkg::*;

  localparam int unsigned LB = VAG_LONG_BITS;

  logic [ADDR_W-1:0] step_off;
  logic [ADDR_W-1:0] long_off;
  logic [ADDR_W-1:0] quad_off;
  logic [ADDR_W-1:0] sel_off;

  // Unsigned product keeps the correct low bits of a signed stride.
  assign step_off = ADDR_W'(elem) * stride;
  assign long_off = {{(ADDR_W-LB){idx_data[LB-1]}}, idx_data[LB-1:0]};
  assign quad_off = idx_data[ADDR_W-1:0];

  always_comb begin
    if (!gather)   sel_off = step_off;
    else if (quad) sel_off = quad_off;
    else           sel_off = long_off;
  end

  assign addr = base + sel_off;
endmodule

// File: rtl/vec_addr_gen.sv
module vec_addr_gen #(
  parameter int unsigned NUM_ELEM = 64,
  parameter int unsigned ADDR_W   = 48,
  parameter int unsigned ELEM_W   = 64
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             start,
  input  logic [ADDR_W-1:0]                base_addr,
  input  logic [ADDR_W-1:0]                stride,
  input  logic                             gather,
  input  logic                             quad,
  input  logic [$clog2(NUM_ELEM+1)-1:0]    vlen,
  input  logic [NUM_ELEM-1:0]              mask,
  input  logic                             mask_en,
  input  logic                             match_true,
  output logic [$clog2(NUM_ELEM)-1:0]      idx_rd_addr,
  input  logic [ELEM_W-1:0]                idx_rd_data,
  output logic                             req_valid,
  input  logic                             req_ready,
  output logic [ADDR_W-1:0]                req_addr,
  output logic [$clog2(NUM_ELEM)-1:0]      req_elem,
  output logic                             req_quad,
  output logic                             done
);
  import vag_pkg::*;

  localparam int unsigned LEN_W = $clog2(NUM_ELEM + 1);
  localparam int unsigned IDX_W = $clog2(NUM_ELEM);

  vag_state_e          state_q;
  logic [ADDR_W-1:0]   base_q;
  logic [ADDR_W-1:0]   stride_q;
  logic                gather_q;
  logic                quad_q;
  logic [NUM_ELEM-1:0] pend_q;

  logic [NUM_ELEM-1:0] en_vec;
  logic [IDX_W-1:0]    pick_idx;
  logic [NUM_ELEM-1:0] pick_oh;
  logic                pick_any;
  logic [ADDR_W-1:0]   next_addr;
  logic                slot_free;

  vag_enable_gen #(.NUM_ELEM(NUM_ELEM), .LEN_W(LEN_W)) u_enable (
    .vlen       (vlen),
    .mask       (mask),
    .mask_en    (mask_en),
    .match_true (match_true),
    .en_vec     (en_vec)
  );

  vag_pick_lowest #(.NUM_ELEM(NUM_ELEM), .IDX_W(IDX_W)) u_pick (
    .pend       (pend_q),
    .sel_idx    (pick_idx),
    .sel_onehot (pick_oh),
    .sel_any    (pick_any)
  );

  vag_addr_calc #(.ADDR_W(ADDR_W), .ELEM_W(ELEM_W), .IDX_W(IDX_W)) u_addr (
    .base     (base_q),
    .stride   (stride_q),
    .gather   (gather_q),
    .quad     (quad_q),
    .elem     (pick_idx),
    .idx_data (idx_rd_data),
    .addr     (next_addr)
  );

  assign idx_rd_addr = pick_idx;
  assign slot_free   = !req_valid || req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= VAG_IDLE;
      pend_q    <= '0;
      base_q    <= '0;
      stride_q  <= '0;
      gather_q  <= 1'b0;
      quad_q    <= 1'b0;
      req_valid <= 1'b0;
      req_addr  <= '0;
      req_elem  <= '0;
      req_quad  <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        VAG_IDLE: begin
          if (start) begin
            base_q   <= base_addr;
            stride_q <= stride;
            gather_q <= gather;
            quad_q   <= quad;
            pend_q   <= en_vec;
            if (en_vec == '0) done <= 1'b1;
            else              state_q <= VAG_RUN;
          end
        end
        VAG_RUN: begin
          if (slot_free) begin
            if (pick_any) begin
              req_valid <= 1'b1;
              req_addr  <= next_addr;
              req_elem  <= pick_idx;
              req_quad  <= quad_q;
              pend_q    <= pend_q & ~pick_oh;
            end else begin
              req_valid <= 1'b0;
              if (req_valid) begin
                done    <= 1'b1;
                state_q <= VAG_IDLE;
              end
            end
          end
        end
        default: state_q <= VAG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vag_checker.sv
module vag_checker #(
  parameter int unsigned NUM_ELEM = 64,
  parameter int unsigned ADDR_W   = 48,
  parameter int unsigned LEN_W    = 7,
  parameter int unsigned IDX_W    = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [LEN_W-1:0]  vlen,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [IDX_W-1:0]  req_elem,
  input logic              done
);
  logic             active;
  logic [LEN_W-1:0] len_cap;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      len_cap <= '0;
    end else if (start && (!active || done)) begin
      active  <= 1'b1;
      len_cap <= vlen;
    end else if (done) begin
      active  <= 1'b0;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!req_valid && !done));

  assert_within_length_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (LEN_W'(req_elem) < len_cap));

  assert_hold_stall_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_elem)));

  assert_ascending_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (!req_valid || (req_elem > $past(req_elem))));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !req_valid);
endmodule

bind vec_addr_gen vag_checker #(
  .NUM_ELEM (NUM_ELEM),
  .ADDR_W   (ADDR_W),
  .LEN_W    (LEN_W),
  .IDX_W    (IDX_W)
) u_vag_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .vlen      (vlen),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .req_elem  (req_elem),
  .done      (done)
);

// File: tb/tb_vec_addr_gen.sv
module tb_vec_addr_gen;
  localparam int NE = 64;
  localparam int AW = 48;
  localparam int EW = 64;

  typedef struct packed {
    logic          gather;
    logic          quad;
    logic [6:0]    vlen;
    logic [63:0]   mask;
    logic          mask_en;
    logic          match_true;
    logic [47:0]   stride;
    logic [47:0]   base;
    logic [7:0]    rdy_pat;
    logic          poke;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t TBL [NV] = '{
    '{gather:1'b0, quad:1'b1, vlen:7'd5,   mask:64'h0,                   mask_en:1'b0, match_true:1'b1,
      stride:48'd8,                  base:48'h0000_0000_1000, rdy_pat:8'hFF, poke:1'b0},
    '{gather:1'b0, quad:1'b0, vlen:7'd10,  mask:64'hAAAA_AAAA_AAAA_AAAA, mask_en:1'b1, match_true:1'b1,
      stride:48'hFFFF_FFFF_FFFC,     base:48'h0000_0010_0000, rdy_pat:8'b1011_0110, poke:1'b1},
    '{gather:1'b0, quad:1'b0, vlen:7'd0,   mask:64'hFFFF_FFFF_FFFF_FFFF, mask_en:1'b0, match_true:1'b1,
      stride:48'd4,                  base:48'h0000_0000_2000, rdy_pat:8'hFF, poke:1'b0},
    '{gather:1'b0, quad:1'b1, vlen:7'd64,  mask:64'hFFFF_FFFF_FFFF_FFFF, mask_en:1'b1, match_true:1'b0,
      stride:48'd8,                  base:48'h0000_0000_3000, rdy_pat:8'hFF, poke:1'b0},
    '{gather:1'b0, quad:1'b0, vlen:7'd64,  mask:64'h0F0F_0F0F_0F0F_0F0F, mask_en:1'b0, match_true:1'b1,
      stride:48'd12,                 base:48'h0000_00AB_0000, rdy_pat:8'hFF, poke:1'b0},
    '{gather:1'b1, quad:1'b0, vlen:7'd20,  mask:64'h0000_0000_000F_3C5D, mask_en:1'b1, match_true:1'b1,
      stride:48'd0,                  base:48'h0000_0100_0000, rdy_pat:8'b1101_1011, poke:1'b0},
    '{gather:1'b1, quad:1'b1, vlen:7'd64,  mask:64'h8000_F00F_0000_FFF0, mask_en:1'b1, match_true:1'b0,
      stride:48'd0,                  base:48'h0000_0200_0000, rdy_pat:8'b0111_1110, poke:1'b1},
    '{gather:1'b0, quad:1'b1, vlen:7'd100, mask:64'h0,                   mask_en:1'b0, match_true:1'b0,
      stride:48'd16,                 base:48'hFFFF_FFFF_FF00, rdy_pat:8'hFF, poke:1'b0}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic [AW-1:0] stride = '0;
  logic          gather = 1'b0;
  logic          quad = 1'b0;
  logic [6:0]    vlen = '0;
  logic [NE-1:0] mask = '0;
  logic          mask_en = 1'b0;
  logic          match_true = 1'b0;
  logic [5:0]    idx_rd_addr;
  logic [EW-1:0] idx_rd_data;
  logic          req_valid;
  logic          req_ready = 1'b0;
  logic [AW-1:0] req_addr;
  logic [5:0]    req_elem;
  logic          req_quad;
  logic          done;

  logic [EW-1:0] idx_mem [NE];
  assign idx_rd_data = idx_mem[idx_rd_addr];

  always #5 clk = ~clk;

  vec_addr_gen #(.NUM_ELEM(NE), .ADDR_W(AW), .ELEM_W(EW)) dut (
    .clk(clk), .rst(rst), .start(start), .base_addr(base_addr), .stride(stride),
    .gather(gather), .quad(quad), .vlen(vlen), .mask(mask), .mask_en(mask_en),
    .match_true(match_true), .idx_rd_addr(idx_rd_addr), .idx_rd_data(idx_rd_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_elem(req_elem), .req_quad(req_quad), .done(done)
  );

  int n_checks = 0;
  int n_errors = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [AW-1:0] exp_addr [NE];
  logic [5:0]    exp_elem [NE];
  int            exp_n;

  task automatic build_expect(input vec_t v);
    exp_n = 0;
    for (int i = 0; i < NE; i++) begin
      logic [AW-1:0] off;
      bit en;
      en = (i < int'(v.vlen)) && (!v.mask_en || (v.mask[i] == v.match_true));
      if (!v.gather)   off = AW'(i) * v.stride;
      else if (v.quad) off = idx_mem[i][AW-1:0];
      else             off = {{(AW-32){idx_mem[i][31]}}, idx_mem[i][31:0]};
      if (en) begin
        exp_addr[exp_n] = v.base + off;
        exp_elem[exp_n] = 6'(i);
        exp_n++;
      end
    end
  endtask

  task automatic run_op(input vec_t v, input string tag);
    int  got;
    bit  prev_evt;
    bit  finished;
    build_expect(v);
    @(negedge clk);
    base_addr = v.base; stride = v.stride; gather = v.gather; quad = v.quad;
    vlen = v.vlen; mask = v.mask; mask_en = v.mask_en; match_true = v.match_true;
    start = 1'b1;
    req_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    got = 0;
    prev_evt = (exp_n == 0);
    finished = 1'b0;
    for (int cyc = 0; cyc < 400 && !finished; cyc++) begin
      // R9: second start with different parameters mid-run must be ignored
      if (v.poke && cyc == 3) begin
        start = 1'b1; base_addr = 48'h0000_7777_0000; vlen = 7'd64;
        gather = ~v.gather; mask_en = 1'b0;
      end else begin
        start = 1'b0;
      end
      req_ready = v.rdy_pat[cyc % 8];
      if (done) begin
        check(got == exp_n, {tag, " R8 done after all requests (count)"}, 64'(got), 64'(exp_n));
        check(prev_evt, {tag, " R8 done timing"}, 64'(prev_evt), 64'd1);
        finished = 1'b1;
      end else begin
        prev_evt = 1'b0;
        if (req_valid) begin
          if (got >= exp_n) begin
            check(1'b0, {tag, " R2/R3 extra request"}, 64'(req_elem), 64'hFFFF);
          end else begin
            check(req_elem == exp_elem[got], {tag, " R7 element order"}, 64'(req_elem), 64'(exp_elem[got]));
            check(req_addr == exp_addr[got], {tag, " R4/R5/R6 address"}, 64'(req_addr), 64'(exp_addr[got]));
            check(req_quad == v.quad, {tag, " R6 width flag"}, 64'(req_quad), 64'(v.quad));
            if (req_ready) begin
              got++;
              if (got == exp_n) prev_evt = 1'b1;
            end
          end
        end
      end
      @(negedge clk);
    end
    start = 1'b0;
    check(finished, {tag, " R8 done seen"}, 64'(finished), 64'd1);
    // R8 single-cycle pulse, R9 no restart from the ignored start
    check(!done, {tag, " R8 done is one cycle"}, 64'(done), 64'd0);
    for (int k = 0; k < 3; k++) begin
      check(!req_valid, {tag, " R9 no activity after done"}, 64'(req_valid), 64'd0);
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NE; i++) begin
      idx_mem[i] = {32'hC0DE_0000 | 32'(i), 32'(i * 40) - 32'd600};
    end
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R1: outputs idle under reset
    check(!req_valid, "R1 req_valid in reset", 64'(req_valid), 64'd0);
    check(!done, "R1 done in reset", 64'(done), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check(!req_valid && !done, "R1 idle after reset", 64'({req_valid, done}), 64'd0);

    for (int t = 0; t < NV; t++) begin
      run_op(TBL[t], $sformatf("vec%0d", t));
    end

    // R2: all-ones length beyond 64 with positive stride, wrap already covered; length 1
    begin
      vec_t one;
      one = TBL[0];
      one.vlen = 7'd1;
      one.base = 48'h0000_0000_0040;
      run_op(one, "len1 R2");
    end

    // R1: reset in mid-run abandons the instruction
    @(negedge clk);
    base_addr = 48'h0000_0000_5000; stride = 48'd4; gather = 1'b0; quad = 1'b0;
    vlen = 7'd64; mask_en = 1'b0; start = 1'b1; req_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    check(req_valid, "R7 request held before reset", 64'(req_valid), 64'd1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(!req_valid && !done, "R1 reset clears request", 64'({req_valid, done}), 64'd0);
    req_ready = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(!req_valid && !done, "R1 abandoned after reset", 64'({req_valid, done}), 64'd0);
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule